// File: doc/BRIEF.md
# Temperature Measurement Sequencer and Linearizer

This block shares one current-input ADC between the regular current-sense conversions and two temperature channels. One channel is an on-die sensor whose output is proportional to absolute temperature. The other is an external sensor. The block drives the ADC mux select. After a programmable number of current-sense results it claims one conversion slot for a temperature channel, and it alternates between the internal and the external channel from one slot to the next.

Each raw temperature code is 7 bits wide and lies in the range 0 to 64. The external code goes through a programmable four-segment piecewise-linear curve. The internal code goes through a single gain-and-offset line. The converted values are held in output registers and marked with a one-cycle valid pulse. They are compared with an alert limit that has hysteresis and with a shutdown limit that latches. Calibration values and limits are loaded through a simple write port.

Top module: `temp_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the outputs are as follows: `adc_sel` is 2'b00, `temp_int` and `temp_ext` are 0, `temp_vld` is 0, `alert` is 0 and `shutdown` is 0.
- R2: `adc_sel` encodes 2'b00 as current sense. A temperature slot begins after N+1 accepted current-sense results, where N is the interval register (address 0x15, 8 bits, reset value 3). The slot holds `adc_sel` until one result is accepted, then returns `adc_sel` to 2'b00.
- R3: Temperature slots alternate between internal (`adc_sel` = 2'b01) and external (2'b10), starting with internal after reset. The value 2'b11 never appears.
- R4: An external code c selects segment k, the highest index whose breakpoint is at or below c. The result is off[k] + floor(slope[k]·(c − bp[k]) / 16). Breakpoint k is written at 0x00+k (7 bits), slope k at 0x04+k (signed 10 bits), and offset k at 0x08+k (signed 12 bits). All fields sit in the low bits of `cfg_wdata`.
- R5: An external code below every breakpoint uses segment 0, which extends segment 0 with a negative difference.
- R6: An internal code c converts to ioff + floor(gain·c / 16). The gain is written at 0x10 (signed 10 bits) and the offset ioff at 0x11 (signed 12 bits). The segment table plays no part in this conversion.
- R7: Every conversion result saturates to the signed 12-bit range −2048 to 2047.
- R8: Consider a temperature result sampled at rising edge E. At edge E+1 the matching temperature output loads the new value. `temp_vld` is high for exactly that one cycle, and `temp_ch` is 0 for internal and 1 for external. The other temperature output does not change. Current-sense results never raise `temp_vld`.
- R9: At the edge after the temperatures change, `alert` sets if either temperature is greater than the set limit (0x12). It clears when both temperatures are less than the clear limit (0x13). Otherwise it holds its value.
- R10: `shutdown` sets on the edge after either temperature exceeds the shutdown limit (0x14). It then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sel | output | 2 | ADC mux select: 00 current, 01 internal, 10 external |
| adc_valid | input | 1 | ADC result strobe |
| adc_code | input | 7 | ADC result code |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| temp_int | output | 12 | Internal temperature, signed |
| temp_ext | output | 12 | External temperature, signed |
| temp_vld | output | 1 | One-cycle pulse on a new reading |
| temp_ch | output | 1 | Channel of the new reading: 0 internal, 1 external |
| alert | output | 1 | Temperature alert with hysteresis |
| shutdown | output | 1 | Latched over-temperature shutdown |

## Verification
The hardest situation to reach is a chosen temperature channel receiving a chosen code, because a slot only opens after the programmed number of current-sense results and the channel choice follows the alternation. The stimulus works as follows. The bench supplies current-sense strobes until it sees `adc_sel` leave 2'b00. It then checks that the slot is the expected channel and delivers the code of interest in that slot. Hysteresis and latching are reached by steering one channel across a limit while the other channel holds a known value.

// File: rtl/temp_pkg.sv
package temp_pkg;
  typedef enum logic [1:0] {
    SEL_CUR = 2'b00,
    SEL_INT = 2'b01,
    SEL_EXT = 2'b10
  } adc_sel_e;

  localparam int ADDR_W    = 5;
  localparam int A_BP0     = 'h00;
  localparam int A_SLOPE0  = 'h04;
  localparam int A_OFF0    = 'h08;
  localparam int A_IGAIN   = 'h10;
  localparam int A_IOFF    = 'h11;
  localparam int A_ALR_SET = 'h12;
  localparam int A_ALR_CLR = 'h13;
  localparam int A_SHUT    = 'h14;
  localparam int A_INTERV  = 'h15;
endpackage

// File: rtl/temp_cfg_regs.sv
module temp_cfg_regs
  import temp_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int CODE_W  = 7,
  parameter int SLOPE_W = 10,
  parameter int TEMP_W  = 12,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 16,
  parameter int DIV_RST = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NSEG-1:0][CODE_W-1:0]       bp,
  output logic [NSEG-1:0][SLOPE_W-1:0]      slope,
  output logic [NSEG-1:0][TEMP_W-1:0]       off,
  output logic [SLOPE_W-1:0]                int_gain,
  output logic [TEMP_W-1:0]                 int_off,
  output logic [TEMP_W-1:0]                 alr_set,
  output logic [TEMP_W-1:0]                 alr_clr,
  output logic [TEMP_W-1:0]                 shut_lim,
  output logic [CNT_W-1:0]                  interval
);
  localparam logic [TEMP_W-1:0] T_TOP = {1'b0, {(TEMP_W-1){1'b1}}};

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        bp[g]    <= '0;
        slope[g] <= '0;
        off[g]   <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(A_BP0 + g))    bp[g]    <= wdata[CODE_W-1:0];
        if (addr == ADDR_W'(A_SLOPE0 + g)) slope[g] <= wdata[SLOPE_W-1:0];
        if (addr == ADDR_W'(A_OFF0 + g))   off[g]   <= wdata[TEMP_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_gain <= '0;
      int_off  <= '0;
      alr_set  <= T_TOP;
      alr_clr  <= T_TOP;
      shut_lim <= T_TOP;
      interval <= CNT_W'(DIV_RST);
    end else if (we) begin
      case (addr)
        ADDR_W'(A_IGAIN):   int_gain <= wdata[SLOPE_W-1:0];
        ADDR_W'(A_IOFF):    int_off  <= wdata[TEMP_W-1:0];
        ADDR_W'(A_ALR_SET): alr_set  <= wdata[TEMP_W-1:0];
        ADDR_W'(A_ALR_CLR): alr_clr  <= wdata[TEMP_W-1:0];
        ADDR_W'(A_SHUT):    shut_lim <= wdata[TEMP_W-1:0];
        ADDR_W'(A_INTERV):  interval <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/temp_seq.sv
module temp_seq
  import temp_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  interval,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  output adc_sel_e          sel,
  output logic              cap_v,
  output logic              cap_ext,
  output logic [CODE_W-1:0] cap_code
);
  logic [CNT_W-1:0] cnt;
  logic             nxt_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= SEL_CUR;
      cnt      <= '0;
      nxt_ext  <= 1'b0;
      cap_v    <= 1'b0;
      cap_ext  <= 1'b0;
      cap_code <= '0;
    end else begin
      cap_v <= 1'b0;
      if (adc_valid) begin
        if (sel == SEL_CUR) begin
          if (cnt >= interval) begin
            cnt <= '0;
            sel <= nxt_ext ? SEL_EXT : SEL_INT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          sel      <= SEL_CUR;
          nxt_ext  <= ~nxt_ext;
          cap_v    <= 1'b1;
          cap_ext  <= (sel == SEL_EXT);
          cap_code <= adc_code;
        end
      end
    end
  end
endmodule

// File: rtl/temp_lin.sv
module temp_lin #(
  parameter int NSEG    = 4,
  parameter int CODE_W  = 7,
  parameter int SLOPE_W = 10,
  parameter int TEMP_W  = 12,
  parameter int FRAC    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cap_v,
  input  logic                          cap_ext,
  input  logic [CODE_W-1:0]             cap_code,
  input  logic [NSEG-1:0][CODE_W-1:0]   bp,
  input  logic [NSEG-1:0][SLOPE_W-1:0]  slope,
  input  logic [NSEG-1:0][TEMP_W-1:0]   off,
  input  logic [SLOPE_W-1:0]            int_gain,
  input  logic [TEMP_W-1:0]             int_off,
  output logic [TEMP_W-1:0]             t_int,
  output logic [TEMP_W-1:0]             t_ext,
  output logic                          vld,
  output logic                          ch
);
  localparam int SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int PROD_W = SLOPE_W + CODE_W + 1;
  localparam int SUM_W  = PROD_W + TEMP_W;
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'(2**(TEMP_W-1) - 1);
  localparam logic signed [SUM_W-1:0] S_MIN = ~S_MAX;

  logic [SEG_W-1:0]          seg;
  logic signed [CODE_W:0]    diff, code_s;
  logic signed [PROD_W-1:0]  prod_e, prod_i;
  logic signed [SUM_W-1:0]   sum_e, sum_i, sum;
  logic [TEMP_W-1:0]         res;

  // Highest segment whose breakpoint does not exceed the code; segment 0 by default.
  always_comb begin
    seg = '0;
    for (int k = 0; k < NSEG; k++)
      if (bp[k] <= cap_code) seg = SEG_W'(k);
  end

  always_comb begin
    code_s = $signed({1'b0, cap_code});
    diff   = code_s - $signed({1'b0, bp[seg]});
    prod_e = PROD_W'($signed(slope[seg])) * PROD_W'(diff);
    prod_i = PROD_W'($signed(int_gain)) * PROD_W'(code_s);
    sum_e  = SUM_W'($signed(off[seg])) + SUM_W'(prod_e >>> FRAC);
    sum_i  = SUM_W'($signed(int_off)) + SUM_W'(prod_i >>> FRAC);
    sum    = cap_ext ? sum_e : sum_i;
    if (sum > S_MAX)      res = TEMP_W'(S_MAX);
    else if (sum < S_MIN) res = TEMP_W'(S_MIN);
    else                  res = TEMP_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_int <= '0;
      t_ext <= '0;
      vld   <= 1'b0;
      ch    <= 1'b0;
    end else begin
      vld <= cap_v;
      if (cap_v) begin
        ch <= cap_ext;
        if (cap_ext) t_ext <= res;
        else         t_int <= res;
      end
    end
  end
endmodule

// File: rtl/temp_limit.sv
module temp_limit #(
  parameter int TEMP_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [TEMP_W-1:0] t_int,
  input  logic signed [TEMP_W-1:0] t_ext,
  input  logic signed [TEMP_W-1:0] alr_set,
  input  logic signed [TEMP_W-1:0] alr_clr,
  input  logic signed [TEMP_W-1:0] shut_lim,
  output logic                     alert,
  output logic                     shutdown
);
  logic over_set, under_clr, over_shut;

  assign over_set  = (t_int > alr_set) || (t_ext > alr_set);
  assign under_clr = (t_int < alr_clr) && (t_ext < alr_clr);
  assign over_shut = (t_int > shut_lim) || (t_ext > shut_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      alert    <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      if (over_set)       alert <= 1'b1;
      else if (under_clr) alert <= 1'b0;
      if (over_shut)      shutdown <= 1'b1;
    end
  end
endmodule

// File: rtl/temp_monitor.sv
module temp_monitor
  import temp_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int CODE_W  = 7,
  parameter int SLOPE_W = 10,
  parameter int TEMP_W  = 12,
  parameter int FRAC    = 4,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 16,
  parameter int DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [1:0]        adc_sel,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [TEMP_W-1:0] temp_int,
  output logic [TEMP_W-1:0] temp_ext,
  output logic              temp_vld,
  output logic              temp_ch,
  output logic              alert,
  output logic              shutdown
);
  logic [NSEG-1:0][CODE_W-1:0]  bp;
  logic [NSEG-1:0][SLOPE_W-1:0] slope;
  logic [NSEG-1:0][TEMP_W-1:0]  off;
  logic [SLOPE_W-1:0]           int_gain;
  logic [TEMP_W-1:0]            int_off, alr_set, alr_clr, shut_lim;
  logic [CNT_W-1:0]             interval;
  adc_sel_e                     sel;
  logic                         cap_v, cap_ext;
  logic [CODE_W-1:0]            cap_code;

  temp_cfg_regs #(
    .NSEG(NSEG), .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .TEMP_W(TEMP_W),
    .CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .bp(bp), .slope(slope), .off(off), .int_gain(int_gain), .int_off(int_off),
    .alr_set(alr_set), .alr_clr(alr_clr), .shut_lim(shut_lim), .interval(interval)
  );

  temp_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .interval(interval), .adc_valid(adc_valid),
    .adc_code(adc_code), .sel(sel), .cap_v(cap_v), .cap_ext(cap_ext),
    .cap_code(cap_code)
  );

  assign adc_sel = sel;

  temp_lin #(
    .NSEG(NSEG), .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .TEMP_W(TEMP_W), .FRAC(FRAC)
  ) u_lin (
    .clk(clk), .rst(rst), .cap_v(cap_v), .cap_ext(cap_ext), .cap_code(cap_code),
    .bp(bp), .slope(slope), .off(off), .int_gain(int_gain), .int_off(int_off),
    .t_int(temp_int), .t_ext(temp_ext), .vld(temp_vld), .ch(temp_ch)
  );

  temp_limit #(.TEMP_W(TEMP_W)) u_lim (
    .clk(clk), .rst(rst), .t_int(temp_int), .t_ext(temp_ext),
    .alr_set(alr_set), .alr_clr(alr_clr), .shut_lim(shut_lim),
    .alert(alert), .shutdown(shutdown)
  );
endmodule

// File: rtl/temp_monitor_chk.sv
module temp_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] adc_sel,
  input logic       adc_valid,
  input logic       temp_vld,
  input logic       shutdown
);
  logic last_int;

  always_ff @(posedge clk) begin
    if (rst) last_int <= 1'b0;
    else if (adc_valid && adc_sel == 2'b01) last_int <= 1'b1;
    else if (adc_valid && adc_sel == 2'b10) last_int <= 1'b0;
  end

  // R3
  sel_code_chk: assert property (@(posedge clk) disable iff (rst) adc_sel != 2'b11);
  // R3
  alt_order_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_sel == 2'b01) |-> !last_int);
  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_sel != 2'b00 && !adc_valid) |=> $stable(adc_sel));
  // R2
  slot_end_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_sel != 2'b00 && adc_valid) |=> (adc_sel == 2'b00));
  // R8
  vld_src_chk: assert property (@(posedge clk) disable iff (rst)
    temp_vld |-> $past(adc_valid && adc_sel != 2'b00, 2));
  // R8
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    temp_vld |=> !temp_vld);
  // R10
  shut_latch_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> shutdown);
endmodule

bind temp_monitor temp_monitor_chk u_chk (.*);

// File: tb/tb_temp_monitor.sv
module tb_temp_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  adc_sel;
  logic        adc_valid = 1'b0;
  logic [6:0]  adc_code = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [11:0] temp_int, temp_ext;
  logic        temp_vld, temp_ch, alert, shutdown;

  int checks = 0;
  int errors = 0;
  int m_bp[4], m_sl[4], m_of[4];
  int m_g, m_io;

  localparam int NV = 8;
  localparam int VI [NV] = '{0, 5, 16, 30, 40, 64, 1, 63};
  localparam int VE [NV] = '{0, 15, 16, 31, 32, 47, 48, 64};

  always #10 clk = ~clk;

  temp_monitor dut (
    .clk(clk), .rst(rst), .adc_sel(adc_sel), .adc_valid(adc_valid),
    .adc_code(adc_code), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .temp_int(temp_int), .temp_ext(temp_ext),
    .temp_vld(temp_vld), .temp_ch(temp_ch), .alert(alert), .shutdown(shutdown)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int ref_ext(input int c);
    int k = 0;
    for (int j = 0; j < 4; j++) if (c >= m_bp[j]) k = j;
    return sat12(m_of[k] + ((m_sl[k] * (c - m_bp[k])) >>> 4));
  endfunction

  function automatic int ref_int(input int c);
    return sat12(m_io + ((m_g * c) >>> 4));
  endfunction

  function automatic int s12(input logic [11:0] v);
    return int'($signed(v));
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_seg(input int k, input int b, input int s, input int o);
    m_bp[k] = b; m_sl[k] = s; m_of[k] = o;
    wr(k, b); wr(4 + k, s); wr(8 + k, o);
  endtask

  task automatic set_int(input int g, input int o);
    m_g = g; m_io = o;
    wr('h10, g); wr('h11, o);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < 4; j++) begin m_bp[j] = 0; m_sl[j] = 0; m_of[j] = 0; end
    m_g = 0; m_io = 0;
  endtask

  // One strobe; returns the select seen just before it.
  task automatic pulse(input int code, output logic [1:0] seen);
    @(negedge clk);
    seen = adc_sel;
    adc_valid = 1'b1; adc_code = 7'(code);
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  // Feed current results until a temperature slot opens, then deliver code.
  // Returns at the negedge after the output update edge.
  task automatic temp_conv(input int code, input logic [1:0] exp_sel);
    int n = 0;
    int prev_int, prev_ext;
    @(negedge clk);
    while (adc_sel == 2'b00 && n < 600) begin
      adc_valid = 1'b1; adc_code = 7'd33;
      @(negedge clk);
      adc_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    chk("R2 slot opens", int'(adc_sel != 2'b00), 1);
    chk("R3 slot channel", int'(adc_sel), int'(exp_sel));
    chk("R8 no vld from current", int'(temp_vld), 0);
    prev_int = s12(temp_int);
    prev_ext = s12(temp_ext);
    adc_valid = 1'b1; adc_code = 7'(code);
    @(negedge clk);
    adc_valid = 1'b0;
    @(negedge clk);
    chk("R8 vld pulse", int'(temp_vld), 1);
    if (exp_sel == 2'b01) begin
      chk("R6 internal value", s12(temp_int), ref_int(code));
      chk("R8 ext untouched", s12(temp_ext), prev_ext);
      chk("R8 ch internal", int'(temp_ch), 0);
    end else begin
      chk("R4 external value", s12(temp_ext), ref_ext(code));
      chk("R8 int untouched", s12(temp_int), prev_int);
      chk("R8 ch external", int'(temp_ch), 1);
    end
  endtask

  task automatic pair(input int ci, input int ce);
    temp_conv(ci, 2'b01);
    temp_conv(ce, 2'b10);
    @(negedge clk);
    chk("R8 vld one cycle", int'(temp_vld), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [1:0] s;
    // R1 reset state
    do_reset;
    chk("R1 adc_sel", int'(adc_sel), 0);
    chk("R1 temp_int", s12(temp_int), 0);
    chk("R1 temp_ext", s12(temp_ext), 0);
    chk("R1 temp_vld", int'(temp_vld), 0);
    chk("R1 alert", int'(alert), 0);
    chk("R1 shutdown", int'(shutdown), 0);

    // R2/R3: default interval 3 -> four current results, then a slot
    for (int i = 0; i < 10; i++) begin
      pulse(7, s);
      chk("R2 R3 default sequence", int'(s), (i == 4) ? 1 : (i == 9) ? 2 : 0);
    end
    wr('h15, 0);
    for (int i = 0; i < 4; i++) begin
      pulse(7, s);
      chk("R2 interval zero", int'(s), (i == 1) ? 1 : (i == 3) ? 2 : 0);
    end

    // Vector table: R4/R6 across every segment
    do_reset;
    wr('h15, 1);
    set_seg(0, 0, 32, 10);
    set_seg(1, 16, 24, 42);
    set_seg(2, 32, -8, 66);
    set_seg(3, 48, 40, 58);
    set_int(20, -50);
    for (int v = 0; v < NV; v++) pair(VI[v], VE[v]);

    // R5: code below first breakpoint extrapolates segment 0
    set_seg(0, 8, 32, 10);
    pair(3, 2);
    chk("R5 below first breakpoint", s12(temp_ext), -2);

    // R7: saturation high on external, low on internal
    set_seg(3, 48, 511, 2040);
    set_int(-512, -2000);
    pair(64, 64);
    chk("R7 saturate high", s12(temp_ext), 2047);
    chk("R7 saturate low", s12(temp_int), -2048);

    // R9/R10: t = 50 + code on both channels
    do_reset;
    wr('h15, 1);
    for (int j = 0; j < 3; j++) set_seg(j, 0, 0, 0);
    set_seg(3, 0, 16, 50);
    set_int(16, 50);
    wr('h12, 100); wr('h13, 80); wr('h14, 110);
    pair(10, 60);
    chk("R9 alert sets on ext", int'(alert), 1);
    chk("R10 no shutdown at limit", int'(shutdown), 0);
    pair(10, 40);
    chk("R9 alert holds in band", int'(alert), 1);
    pair(10, 20);
    chk("R9 alert clears", int'(alert), 0);
    pair(60, 20);
    chk("R9 alert sets on int", int'(alert), 1);
    pair(0, 61);
    chk("R10 shutdown sets", int'(shutdown), 1);
    pair(0, 0);
    chk("R9 alert clears again", int'(alert), 0);
    chk("R10 shutdown latched", int'(shutdown), 1);
    do_reset;
    chk("R10 reset clears shutdown", int'(shutdown), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule